// File: doc/BRIEF.md
# Host-to-Coprocessor Shared RAM Window

This block lets a host expansion-slot bus reach the 32 KB local RAM of a coprocessor on a disk controller card. The slot bus presents three device selects: a 16-byte control space, a 256-byte slot page and a 2 KB shared window. Each host access is one clock long and qualified by a strobe. The block turns it into a 15-bit local RAM address, a write enable and write data. Read data comes back to the host one clock later.

A 4-bit bank register decides which 1 KB slice of the low 16 KB of RAM appears in the lower half of the shared window. Any access to the control space loads the register from the low address nibble. The upper half of the window is always fixed on the last 1 KB of RAM. The slot page is a read-only view of the 256 bytes at 0x7B00. A peek input lets a debugger read the control space without moving the bank.

The read response is a small state machine. Its states are RSP_IDLE (no read pending), RSP_RAM (RAM data is returned) and RSP_ZERO (zero is returned for a control-space read). On every clock the next state is chosen from the current access alone, with these transitions:
- A strobed read of the page or the window goes to RSP_RAM.
- A strobed read of the control space goes to RSP_ZERO.
- Anything else, including writes, goes to RSP_IDLE.

The transitions are the same from every state, so back-to-back reads are supported.

Top module: `slot_ram_window`

## Requirements
- R1: After reset the bank register holds 0, so window offset 0x000 to 0x3FF maps to local address 0x0000 plus the offset.
- R2: A strobed access to the control space loads host_addr[3:0] into the bank register. This applies to writes, and to reads with peek low. The host data value has no effect on the bank.
- R3: A strobed control-space read returns host_rdata = 0 with host_rvalid = 1 on the following clock.
- R4: A strobed control-space read with host_peek = 1 leaves the bank register unchanged.
- R5: A strobed slot-page read drives ram_addr = 0x7B00 + host_addr[7:0]. It returns that RAM byte on the following clock.
- R6: A strobed slot-page write never asserts ram_we, and the RAM byte is left unchanged.
- R7: A strobed window access with host_addr[10] = 0 drives ram_addr = bank * 1024 + host_addr[9:0].
- R8: A strobed window access with host_addr[10] = 1 drives ram_addr = 0x7C00 + host_addr[9:0], whatever the bank holds.
- R9: Window writes assert ram_we for the strobe cycle, with ram_wdata = host_wdata. Window reads return the addressed RAM byte.
- R10: host_rvalid is 1 for exactly the one clock after each strobed read and is 0 after writes.
- R11: Without host_strobe, ram_we and host_rvalid stay 0 and the bank register does not change, even if selects are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_strobe | input | 1 | Host access cycle qualifier |
| host_we | input | 1 | 1 = write, 0 = read |
| host_peek | input | 1 | Debug read: no bank side effect |
| ctrl_sel | input | 1 | Control-space select |
| page_sel | input | 1 | Slot-page select |
| xwin_sel | input | 1 | Shared-window select |
| host_addr | input | 11 | Host offset inside the selected region |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one clock after the read |
| ram_addr | output | 15 | Local RAM address |
| ram_we | output | 1 | Local RAM write enable |
| ram_wdata | output | 8 | Local RAM write data |
| ram_rdata | input | 8 | Local RAM read data, one clock after the address |

## Verification
The assertions assume the following about the inputs:
- At most one region select is high in a strobed cycle.
- The local RAM returns the addressed byte on the clock after the address is presented.

The bench drives one select at a time and models the RAM with a registered read, so every access stays inside these assumptions. It changes inputs only at the falling edge. This keeps each strobe exactly one rising edge long, as the single-cycle-access rule requires.

// File: rtl/slotwin_pkg.sv
package slotwin_pkg;
    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_PAGE,
        REG_XLO,
        REG_XHI
    } region_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_RAM,
        RSP_ZERO
    } rsp_state_t;
endpackage

// File: rtl/slotwin_decode.sv
module slotwin_decode
    import slotwin_pkg::*;
(
    input  logic    strobe,
    input  logic    ctrl_sel,
    input  logic    page_sel,
    input  logic    xwin_sel,
    input  logic    upper_half,
    output region_t region
);
    always_comb begin
        region = REG_NONE;
        if (strobe) begin
            if (ctrl_sel)
                region = REG_CTRL;
            else if (page_sel)
                region = REG_PAGE;
            else if (xwin_sel)
                region = upper_half ? REG_XHI : REG_XLO;
        end
    end
endmodule

// File: rtl/slotwin_bank.sv
module slotwin_bank
    import slotwin_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_t           region,
    input  logic              is_write,
    input  logic              peek,
    input  logic [BANK_W-1:0] nibble,
    output logic [BANK_W-1:0] bank
);
    logic load;

    assign load = (region == REG_CTRL) && (is_write || !peek);

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (load)
            bank <= nibble;
    end
endmodule

// File: rtl/slotwin_addr_map.sv
module slotwin_addr_map
    import slotwin_pkg::*;
#(
    parameter int              LOCAL_AW  = 15,
    parameter int              BANK_W    = 4,
    parameter int              WIN_AW    = 10,
    parameter int              PAGE_AW   = 8,
    parameter logic [LOCAL_AW-1:0] PAGE_BASE = 15'h7B00,
    parameter logic [LOCAL_AW-1:0] HI_BASE   = 15'h7C00
) (
    input  region_t             region,
    input  logic [BANK_W-1:0]   bank,
    input  logic [WIN_AW-1:0]   offset,
    output logic [LOCAL_AW-1:0] addr
);
    localparam int LO_W = BANK_W + WIN_AW;

    logic [LO_W-1:0] lo_addr;

    assign lo_addr = {bank, offset};

    always_comb begin
        unique case (region)
            REG_PAGE: addr = PAGE_BASE + LOCAL_AW'(offset[PAGE_AW-1:0]);
            REG_XLO:  addr = LOCAL_AW'(lo_addr);
            REG_XHI:  addr = HI_BASE + LOCAL_AW'(offset);
            default:  addr = '0;
        endcase
    end
endmodule

// File: rtl/slotwin_rsp_fsm.sv
module slotwin_rsp_fsm
    import slotwin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_t           region,
    input  logic              is_write,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    rsp_state_t state_q;
    rsp_state_t state_d;

    always_comb begin
        state_d = RSP_IDLE;
        if (!is_write) begin
            unique case (region)
                REG_CTRL:                  state_d = RSP_ZERO;
                REG_PAGE, REG_XLO, REG_XHI: state_d = RSP_RAM;
                default:                   state_d = RSP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RSP_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RSP_RAM: begin
                rdata  = ram_rdata;
                rvalid = 1'b1;
            end
            RSP_ZERO: begin
                rdata  = '0;
                rvalid = 1'b1;
            end
            default: begin
                rdata  = '0;
                rvalid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/slot_ram_window.sv
module slot_ram_window
    import slotwin_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LOCAL_AW = 15,
    parameter int BANK_W   = 4,
    parameter int WIN_AW   = 10,
    parameter int PAGE_AW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_strobe,
    input  logic                host_we,
    input  logic                host_peek,
    input  logic                ctrl_sel,
    input  logic                page_sel,
    input  logic                xwin_sel,
    input  logic [WIN_AW:0]     host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic [LOCAL_AW-1:0] ram_addr,
    output logic                ram_we,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata
);
    region_t           region;
    logic [BANK_W-1:0] bank_q;

    slotwin_decode i_decode (
        .strobe     (host_strobe),
        .ctrl_sel   (ctrl_sel),
        .page_sel   (page_sel),
        .xwin_sel   (xwin_sel),
        .upper_half (host_addr[WIN_AW]),
        .region     (region)
    );

    slotwin_bank #(.BANK_W(BANK_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .region   (region),
        .is_write (host_we),
        .peek     (host_peek),
        .nibble   (host_addr[BANK_W-1:0]),
        .bank     (bank_q)
    );

    slotwin_addr_map #(
        .LOCAL_AW (LOCAL_AW),
        .BANK_W   (BANK_W),
        .WIN_AW   (WIN_AW),
        .PAGE_AW  (PAGE_AW)
    ) i_map (
        .region (region),
        .bank   (bank_q),
        .offset (host_addr[WIN_AW-1:0]),
        .addr   (ram_addr)
    );

    slotwin_rsp_fsm #(.DATA_W(DATA_W)) i_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .region    (region),
        .is_write  (host_we),
        .ram_rdata (ram_rdata),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );

    assign ram_we    = host_we && ((region == REG_XLO) || (region == REG_XHI));
    assign ram_wdata = host_wdata;
endmodule

// File: rtl/slotwin_checker.sv
module slotwin_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_strobe,
    input logic        host_we,
    input logic        host_peek,
    input logic        ctrl_sel,
    input logic        page_sel,
    input logic        xwin_sel,
    input logic [10:0] host_addr,
    input logic [7:0]  host_wdata,
    input logic [7:0]  host_rdata,
    input logic        host_rvalid,
    input logic [14:0] ram_addr,
    input logic        ram_we,
    input logic [7:0]  ram_wdata,
    input logic [3:0]  bank_q
);
    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && ctrl_sel && (host_we || !host_peek)) |=> bank_q == $past(host_addr[3:0]));

    assert_ctrl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && ctrl_sel && !host_we) |=> (host_rvalid && host_rdata == 8'h00));

    assert_peek_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && ctrl_sel && !host_we && host_peek) |=> $stable(bank_q));

    assert_page_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && page_sel && !ctrl_sel) |-> ram_addr == 15'h7B00 + {7'd0, host_addr[7:0]});

    assert_page_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && page_sel && !ctrl_sel) |-> !ram_we);

    assert_high_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_strobe && xwin_sel && !ctrl_sel && !page_sel && host_addr[10])
            |-> ram_addr == 15'h7C00 + {5'd0, host_addr[9:0]});

    assert_write_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (host_strobe && host_we && ram_wdata == host_wdata));

    assert_rvalid_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_strobe && !host_we));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_strobe |-> !ram_we);

    assert_idle_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_strobe |=> $stable(bank_q));
endmodule

bind slot_ram_window slotwin_checker i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_strobe (host_strobe),
    .host_we     (host_we),
    .host_peek   (host_peek),
    .ctrl_sel    (ctrl_sel),
    .page_sel    (page_sel),
    .xwin_sel    (xwin_sel),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .bank_q      (bank_q)
);

// File: tb/test_slot_ram_window.sv
module test_slot_ram_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_strobe = 1'b0;
    logic        host_we = 1'b0;
    logic        host_peek = 1'b0;
    logic        ctrl_sel = 1'b0;
    logic        page_sel = 1'b0;
    logic        xwin_sel = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic [14:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [14:0] cap_addr;
    logic        cap_we;
    logic [7:0]  cap_rdata;
    logic        cap_rvalid;

    logic [7:0] mem [int];

    always #2 clk = ~clk;

    slot_ram_window i_slot_ram_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_strobe (host_strobe),
        .host_we     (host_we),
        .host_peek   (host_peek),
        .ctrl_sel    (ctrl_sel),
        .page_sel    (page_sel),
        .xwin_sel    (xwin_sel),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .ram_addr    (ram_addr),
        .ram_we      (ram_we),
        .ram_wdata   (ram_wdata),
        .ram_rdata   (ram_rdata)
    );

    function automatic logic [7:0] model_rd(input logic [14:0] a);
        if (mem.exists(int'(a)))
            return mem[int'(a)];
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    // local RAM with one clock of read latency
    always @(posedge clk) begin
        ram_rdata <= model_rd(ram_addr);
        if (ram_we)
            mem[int'(ram_addr)] = ram_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one strobed cycle; captures address/we during it and response after
    task automatic access(input logic c, input logic p, input logic x, input logic we,
                          input logic pk, input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        host_strobe = 1'b1;
        ctrl_sel = c; page_sel = p; xwin_sel = x;
        host_we = we; host_peek = pk; host_addr = a; host_wdata = d;
        #1;
        cap_addr = ram_addr;
        cap_we   = ram_we;
        @(negedge clk);
        host_strobe = 1'b0;
        ctrl_sel = 1'b0; page_sel = 1'b0; xwin_sel = 1'b0;
        host_we = 1'b0; host_peek = 1'b0;
        #1;
        cap_rdata  = host_rdata;
        cap_rvalid = host_rvalid;
    endtask

    task automatic probe_bank(input string req, input logic [3:0] exp_bank, input logic [9:0] off);
        logic [14:0] ea;
        ea = {1'b0, exp_bank, off};
        access(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, {1'b0, off}, 8'h00);
        chk(req, 32'(cap_addr), 32'(ea));
        chk(req, 32'(cap_rdata), 32'(model_rd(ea)));
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1 rvalid after reset", 32'(host_rvalid), 0);
        chk("R11 we idle", 32'(ram_we), 0);
        probe_bank("R1 bank zero", 4'h0, 10'h155);
    endtask

    task automatic t_bank_sweep;
        for (int b = 0; b < 16; b++) begin
            logic [14:0] ea;
            access(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'(b), 8'(~b));
            ea = {1'b0, 4'(b), 10'h2A0};
            access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h2A0, 8'(8'h30 + b));
            chk("R7 low window write addr", 32'(cap_addr), 32'(ea));
            chk("R9 write enable", 32'(cap_we), 1);
            chk("R10 no rvalid after write", 32'(cap_rvalid), 0);
            probe_bank("R2 R9 bank read back", 4'(b), 10'h2A0);
            chk("R9 data", 32'(cap_rdata), 32'(8'h30 + b));
        end
    endtask

    task automatic t_ctrl_read;
        access(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'h7FA, 8'h00);
        chk("R3 ctrl read zero", 32'(cap_rdata), 0);
        chk("R3 ctrl read valid", 32'(cap_rvalid), 1);
        probe_bank("R2 read loads bank", 4'hA, 10'h001);
    endtask

    task automatic t_peek;
        access(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 11'h003, 8'h00);
        chk("R3 peek read zero", 32'(cap_rdata), 0);
        probe_bank("R4 peek keeps bank", 4'hA, 10'h3FF);
        access(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 11'h005, 8'hFF);
        probe_bank("R2 peek write loads", 4'h5, 10'h000);
    endtask

    task automatic t_page;
        access(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'h042, 8'h00);
        chk("R5 page addr", 32'(cap_addr), 32'h7B42);
        chk("R5 page data", 32'(cap_rdata), 32'(model_rd(15'h7B42)));
        access(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 11'h042, 8'h99);
        chk("R6 page write no we", 32'(cap_we), 0);
        access(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'h042, 8'h00);
        chk("R6 page unchanged", 32'(cap_rdata), 32'(15'h7B42 & 15'h00FF ^ 15'h007B));
    endtask

    task automatic t_high;
        access(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'h007, 8'h00);
        access(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h500, 8'hC3);
        chk("R8 high addr bank7", 32'(cap_addr), 32'h7D00);
        chk("R9 high we", 32'(cap_we), 1);
        access(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'h002, 8'h00);
        access(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h500, 8'h00);
        chk("R8 high addr bank2", 32'(cap_addr), 32'h7D00);
        chk("R8 high data", 32'(cap_rdata), 32'hC3);
        access(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h7FF, 8'h00);
        chk("R8 top addr", 32'(cap_addr), 32'h7FFF);
    endtask

    task automatic t_timing;
        access(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h010, 8'h00);
        chk("R10 rvalid next clock", 32'(cap_rvalid), 1);
        @(negedge clk); #1;
        chk("R10 rvalid one clock", 32'(host_rvalid), 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        ctrl_sel = 1'b1; xwin_sel = 1'b0; host_we = 1'b1; host_addr = 11'h009;
        repeat (3) begin
            @(negedge clk); #1;
            chk("R11 no we", 32'(ram_we), 0);
            chk("R11 no rvalid", 32'(host_rvalid), 0);
        end
        ctrl_sel = 1'b0; host_we = 1'b0;
        probe_bank("R11 bank held", 4'h2, 10'h0F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank_sweep();
        t_ctrl_read();
        t_peek();
        t_page();
        t_high();
        t_timing();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule